// File: doc/BRIEF.md
# Single-Bit Alias Remapper

This unit sits on the request path between a processor's memory-mapped master port and the bus that leads to memory and peripherals. A window of word addresses is reserved as an alias space. Each word in that window stands for one bit of a backing region. Software can then read or write a single bit with an ordinary word access.

Any access that falls in the alias window is turned into an access to the backing region. A read fetches the backing word and returns only the selected bit, in bit 0. A write becomes a read of the backing word, a one-cycle merge of the new bit, and a write-back. The downstream lock signal is held over that whole sequence, so no other master can slip in between the read and the write.

Accesses outside the window are routed straight through by combinational logic. They take no extra cycles and are not changed.

Top module: `bitband_remap`

## Requirements
- R1: After reset, with no upstream request, `up_ready`, `dn_req` and `dn_lock` are all low.
- R2: An access outside the alias window is forwarded with the same address, write flag, write data and byte enables. Its read data and ready come straight back from downstream, so `up_ready` rises in the same cycle as `dn_ready` and the access takes no extra cycles.
- R3: An alias address `ALIAS_BASE + off*32 + b*4` selects bit `b` (0 to 7) of the byte at `REGION_BASE + off`. The downstream read goes to that byte's word-aligned address, and the bit sits at position `(off mod 4)*8 + b` of the 32-bit word.
- R4: An alias read returns the selected backing bit in `up_rdata[0]`, with bits 31:1 zero. It issues no downstream write.
- R5: An alias write changes only the selected bit of the backing word. The downstream write carries a single byte enable: bit `off mod 4` of `dn_be`.
- R6: For an alias write, only `up_wdata[0]` sets the new bit value. Bits 31:1 of the write data have no effect.
- R7: During an alias write, `dn_lock` is high from the first cycle of the downstream read until the downstream write is accepted, including the merge cycle between them. It is low during alias reads and pass-through accesses.
- R8: An alias read raises `up_ready` exactly one cycle after its downstream read is accepted. An alias write issues its downstream write two cycles after the read is accepted, and raises `up_ready` one cycle after the write is accepted. With W wait cycles per downstream access, that gives W+2 cycles for a read and 2W+4 cycles for a write, counted from the request.
- R9: The last word of the alias window counts as alias and maps to bit 7 of the last byte of the region. The word just below `ALIAS_BASE`, and the address one past the end of the window, both pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_req | input | 1 | Upstream request; held until `up_ready` |
| up_we | input | 1 | Upstream write flag |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_be | input | 4 | Upstream byte enables |
| up_ready | output | 1 | Upstream completion strobe |
| up_rdata | output | 32 | Upstream read data, valid with `up_ready` |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_be | output | 4 | Downstream byte enables |
| dn_lock | output | 1 | Downstream bus lock for the read-modify-write sequence |
| dn_ready | input | 1 | Downstream completion strobe |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The bench exercises the unit with four kinds of access:
- **Pass-through reads and writes.** These use zero and non-zero wait cycles. They show whether the bypass adds latency or changes any field.
- **Alias reads.** These sweep every bit of one byte and a bit in a different byte lane. They show whether the bit index and the lane are decoded correctly and whether the other result bits stay clear.
- **Alias writes.** Some clear a set bit using write data whose upper bits are all ones. Others set a clear bit. Each is followed by a plain read of the whole word. Together they separate a correct single-bit merge from a merge that uses the wrong write-data bit or leaks into other bits.
- **Window-edge addresses and longer wait counts.** These check the alias-window decode at its boundaries and the cycle count of each phase of the sequence.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PASS   = 3'd1,
        ST_RD     = 3'd2,
        ST_MODIFY = 3'd3,
        ST_WR     = 3'd4,
        ST_RESP   = 3'd5
    } bb_state_e;

endpackage

// File: rtl/bitband_alias_decode.sv
module bitband_alias_decode #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                REGION_LOG2 = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000,
    parameter int                BITPOS_W    = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [ADDR_W-1:0]   word_addr,
    output logic [BITPOS_W-1:0] bit_pos
);
    localparam int SPAN_LOG2 = REGION_LOG2 + 5;
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;

    logic [REGION_LOG2-1:0] byte_off;
    logic [2:0]             bit_idx;
    logic [ADDR_W-1:0]      byte_addr;
    logic                   unused_low;

    assign byte_off   = addr[SPAN_LOG2-1:5];
    assign bit_idx    = addr[4:2];
    assign unused_low = ^addr[1:0];
    assign hit        = (addr[ADDR_W-1:SPAN_LOG2] == ALIAS_BASE[ADDR_W-1:SPAN_LOG2]);
    assign byte_addr  = REGION_BASE + {{(ADDR_W-REGION_LOG2){1'b0}}, byte_off};

    generate
        if (LANES > 1) begin : g_multi_lane
            assign word_addr = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            assign bit_pos   = {byte_addr[LANE_W-1:0], bit_idx};
        end else begin : g_single_lane
            assign word_addr = byte_addr;
            assign bit_pos   = bit_idx;
        end
    endgenerate

endmodule

// File: rtl/bitband_bit_ops.sv
module bitband_bit_ops #(
    parameter int DATA_W   = 32,
    parameter int BITPOS_W = $clog2(DATA_W),
    parameter int LANES    = DATA_W / 8
) (
    input  logic [DATA_W-1:0]   word_in,
    input  logic [BITPOS_W-1:0] bit_pos,
    input  logic                new_bit,
    output logic                bit_out,
    output logic [DATA_W-1:0]   word_out,
    output logic [LANES-1:0]    lane_be
);
    always_comb begin
        bit_out           = word_in[bit_pos];
        word_out          = word_in;
        word_out[bit_pos] = new_bit;
    end

    generate
        if (LANES > 1) begin : g_lane_sel
            always_comb begin
                lane_be = '0;
                lane_be[bit_pos[BITPOS_W-1:3]] = 1'b1;
            end
        end else begin : g_lane_all
            assign lane_be = '1;
        end
    endgenerate

endmodule

// File: rtl/bitband_remap.sv
module bitband_remap
    import bitband_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                REGION_LOG2 = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_req,
    input  logic                up_we,
    input  logic [ADDR_W-1:0]   up_addr,
    input  logic [DATA_W-1:0]   up_wdata,
    input  logic [DATA_W/8-1:0] up_be,
    output logic                up_ready,
    output logic [DATA_W-1:0]   up_rdata,
    output logic                dn_req,
    output logic                dn_we,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic [DATA_W-1:0]   dn_wdata,
    output logic [DATA_W/8-1:0] dn_be,
    output logic                dn_lock,
    input  logic                dn_ready,
    input  logic [DATA_W-1:0]   dn_rdata
);
    localparam int LANES    = DATA_W / 8;
    localparam int BITPOS_W = $clog2(DATA_W);

    typedef struct packed {
        bb_state_e             state;
        logic                  is_wr;
        logic                  new_bit;
        logic [ADDR_W-1:0]     word_addr;
        logic [BITPOS_W-1:0]   bit_pos;
        logic [DATA_W-1:0]     word;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic                dec_hit;
    logic [ADDR_W-1:0]   dec_word;
    logic [BITPOS_W-1:0] dec_pos;
    logic                sel_bit;
    logic [DATA_W-1:0]   merged_word;
    logic [LANES-1:0]    merge_be;

    bitband_alias_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .REGION_LOG2 (REGION_LOG2),
        .REGION_BASE (REGION_BASE),
        .ALIAS_BASE  (ALIAS_BASE),
        .BITPOS_W    (BITPOS_W)
    ) u_decode (
        .addr      (up_addr),
        .hit       (dec_hit),
        .word_addr (dec_word),
        .bit_pos   (dec_pos)
    );

    bitband_bit_ops #(
        .DATA_W   (DATA_W),
        .BITPOS_W (BITPOS_W),
        .LANES    (LANES)
    ) u_bit_ops (
        .word_in  (ctx_q.word),
        .bit_pos  (ctx_q.bit_pos),
        .new_bit  (ctx_q.new_bit),
        .bit_out  (sel_bit),
        .word_out (merged_word),
        .lane_be  (merge_be)
    );

    always_comb begin
        ctx_d    = ctx_q;
        up_ready = 1'b0;
        up_rdata = '0;
        dn_req   = 1'b0;
        dn_we    = 1'b0;
        dn_addr  = ctx_q.word_addr;
        dn_wdata = ctx_q.word;
        dn_be    = '0;
        dn_lock  = 1'b0;

        case (ctx_q.state)
            ST_IDLE: begin
                if (up_req && dec_hit) begin
                    ctx_d.state     = ST_RD;
                    ctx_d.is_wr     = up_we;
                    ctx_d.new_bit   = up_wdata[0];
                    ctx_d.word_addr = dec_word;
                    ctx_d.bit_pos   = dec_pos;
                end else if (up_req) begin
                    dn_req   = 1'b1;
                    dn_we    = up_we;
                    dn_addr  = up_addr;
                    dn_wdata = up_wdata;
                    dn_be    = up_be;
                    up_ready = dn_ready;
                    up_rdata = dn_rdata;
                    if (!dn_ready) begin
                        ctx_d.state = ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                dn_req   = up_req;
                dn_we    = up_we;
                dn_addr  = up_addr;
                dn_wdata = up_wdata;
                dn_be    = up_be;
                up_ready = dn_ready;
                up_rdata = dn_rdata;
                if (dn_ready || !up_req) begin
                    ctx_d.state = ST_IDLE;
                end
            end
            ST_RD: begin
                dn_req  = 1'b1;
                dn_be   = '1;
                dn_lock = ctx_q.is_wr;
                if (dn_ready) begin
                    ctx_d.word  = dn_rdata;
                    ctx_d.state = ctx_q.is_wr ? ST_MODIFY : ST_RESP;
                end
            end
            ST_MODIFY: begin
                dn_lock     = 1'b1;
                ctx_d.word  = merged_word;
                ctx_d.state = ST_WR;
            end
            ST_WR: begin
                dn_req  = 1'b1;
                dn_we   = 1'b1;
                dn_be   = merge_be;
                dn_lock = 1'b1;
                if (dn_ready) begin
                    ctx_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                up_ready = 1'b1;
                if (!ctx_q.is_wr) begin
                    up_rdata[0] = sel_bit;
                end
                ctx_d.state = ST_IDLE;
            end
            default: begin
                ctx_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q.state     <= ST_IDLE;
            ctx_q.is_wr     <= 1'b0;
            ctx_q.new_bit   <= 1'b0;
            ctx_q.word_addr <= '0;
            ctx_q.bit_pos   <= '0;
            ctx_q.word      <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

endmodule

// File: rtl/bitband_remap_chk.sv
module bitband_remap_chk #(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                REGION_LOG2 = 20,
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4200_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                up_req,
    input logic                up_we,
    input logic [ADDR_W-1:0]   up_addr,
    input logic [DATA_W-1:0]   up_wdata,
    input logic [DATA_W/8-1:0] up_be,
    input logic                up_ready,
    input logic [DATA_W-1:0]   up_rdata,
    input logic                dn_req,
    input logic                dn_we,
    input logic [ADDR_W-1:0]   dn_addr,
    input logic [DATA_W-1:0]   dn_wdata,
    input logic [DATA_W/8-1:0] dn_be,
    input logic                dn_lock,
    input logic                dn_ready,
    input logic [DATA_W-1:0]   dn_rdata
);
    localparam int SPAN_LOG2 = REGION_LOG2 + 5;

    logic in_win;
    assign in_win = (up_addr[ADDR_W-1:SPAN_LOG2] == ALIAS_BASE[ADDR_W-1:SPAN_LOG2]);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !up_req |-> (!dn_req && !dn_lock)) else $error("idle quiet");  // R1

    AST_PASS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && !in_win) |-> (dn_req && dn_addr == up_addr && dn_we == up_we
                                 && dn_be == up_be && dn_wdata == up_wdata)) else $error("pass fields");  // R2

    AST_PASS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && !in_win) |-> (up_ready == dn_ready && up_rdata == dn_rdata)) else $error("pass return");  // R2

    AST_READ_BIT0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && !up_we && up_ready) |-> (up_rdata[DATA_W-1:1] == '0)) else $error("read bits");  // R4

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && !up_we) |-> !(dn_req && dn_we)) else $error("read wrote");  // R4

    AST_WRITE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && dn_req && dn_we) |-> ($countones(dn_be) == 1)) else $error("lane");  // R5

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && up_we && dn_req) |-> dn_lock) else $error("unlocked");  // R7

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_lock && !(dn_req && dn_we && dn_ready)) |=> dn_lock) else $error("lock drop");  // R7

    AST_READ_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && !up_we) |-> !dn_lock) else $error("read locked");  // R7

    AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && dn_req) |-> !up_ready) else $error("early ready");  // R8

    AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && in_win && dn_req && dn_ready && (dn_we || !up_we)) |=> up_ready) else $error("late ready");  // R8

endmodule

bind bitband_remap bitband_remap_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_LOG2 (REGION_LOG2),
    .ALIAS_BASE  (ALIAS_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_req   (up_req),
    .up_we    (up_we),
    .up_addr  (up_addr),
    .up_wdata (up_wdata),
    .up_be    (up_be),
    .up_ready (up_ready),
    .up_rdata (up_rdata),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_be    (dn_be),
    .dn_lock  (dn_lock),
    .dn_ready (dn_ready),
    .dn_rdata (dn_rdata)
);

// File: tb/tb_bitband_remap.sv
`timescale 1ns/1ps
module tb_bitband_remap;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_req, up_we;
    logic [31:0] up_addr, up_wdata;
    logic [3:0]  up_be;
    logic        up_ready;
    logic [31:0] up_rdata;
    logic        dn_req, dn_we, dn_lock;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic        dn_ready = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int failures = 0;
    int wait_cfg = 0;
    int cnt = 0;
    bit done = 0;

    logic [31:0] mem     [logic [29:0]];
    logic [31:0] ref_mem [logic [29:0]];

    always #5 clk = ~clk;

    bitband_remap dut (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata), .up_be(up_be),
        .up_ready(up_ready), .up_rdata(up_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_be(dn_be),
        .dn_lock(dn_lock), .dn_ready(dn_ready), .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a[31:2])) return mem[a[31:2]];
        return 32'h0;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        if (ref_mem.exists(a[31:2])) return ref_mem[a[31:2]];
        return 32'h0;
    endfunction

    // downstream slave: answers after wait_cfg wait cycles
    always @(negedge clk) begin
        #1;
        dn_ready = dn_req && (cnt == wait_cfg);
        dn_rdata = mem_rd(dn_addr);
    end

    always @(posedge clk) begin
        if (dn_req && dn_ready && dn_we) begin
            logic [31:0] w;
            w = mem_rd(dn_addr);
            for (int i = 0; i < 4; i++) if (dn_be[i]) w[i*8 +: 8] = dn_wdata[i*8 +: 8];
            mem[dn_addr[31:2]] = w;
        end
        if (dn_req && !dn_ready) cnt = cnt + 1;
        else cnt = 0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                          input logic [3:0] be, input int w,
                          output logic [31:0] rdata, output int lat, output int lock_cyc,
                          output logic [3:0] wr_be, output logic [31:0] first_addr);
        bit seen;
        wait_cfg = w;
        @(negedge clk);
        up_req = 1'b1; up_we = we; up_addr = addr; up_wdata = wdata; up_be = be;
        lat = -1; lock_cyc = 0; wr_be = 4'h0; first_addr = 32'hFFFF_FFFF; rdata = 32'h0;
        seen = 0;
        for (int n = 0; n < 64; n++) begin
            #2;
            if (dn_lock) lock_cyc++;
            if (dn_req && !seen) begin first_addr = dn_addr; seen = 1; end
            if (dn_req && dn_we) wr_be = dn_be;
            if (up_ready) begin rdata = up_rdata; lat = n; break; end
            @(negedge clk);
        end
        @(negedge clk);
        up_req = 1'b0; up_we = 1'b0;
    endtask

    function automatic logic [31:0] alias_of(input int off, input int b);
        return 32'h4200_0000 + 32'(off) * 32 + 32'(b) * 4;
    endfunction

    task automatic alias_read(input int off, input int b, input int w, input string tag);
        logic [31:0] waddr, rd, fa; int lat, lk; logic [3:0] wb; logic bitv;
        waddr = (32'h4000_0000 + 32'(off)) & 32'hFFFF_FFFC;
        bitv  = ref_rd(waddr)[(off % 4) * 8 + b];
        access(1'b0, alias_of(off, b), 32'h0, 4'hF, w, rd, lat, lk, wb, fa);
        chk(rd == {31'h0, bitv}, "R4", {tag, " alias read data"}, rd, {31'h0, bitv});
        chk(fa == waddr, "R3", {tag, " backing word address"}, fa, waddr);
        chk(wb == 4'h0, "R4", {tag, " no downstream write"}, {28'h0, wb}, 32'h0);
        chk(lat == w + 2, "R8", {tag, " read latency"}, 32'(lat), 32'(w + 2));
        chk(lk == 0, "R7", {tag, " read lock cycles"}, 32'(lk), 32'h0);
    endtask

    task automatic alias_write(input int off, input int b, input logic [31:0] wdata,
                               input int w, input string tag);
        logic [31:0] waddr, exp, rd, fa; int lat, lk; logic [3:0] wb;
        waddr = (32'h4000_0000 + 32'(off)) & 32'hFFFF_FFFC;
        exp = ref_rd(waddr);
        exp[(off % 4) * 8 + b] = wdata[0];
        ref_mem[waddr[31:2]] = exp;
        access(1'b1, alias_of(off, b), wdata, 4'hF, w, rd, lat, lk, wb, fa);
        chk(fa == waddr, "R3", {tag, " backing word address"}, fa, waddr);
        chk(wb == 4'(1 << (off % 4)), "R5", {tag, " single lane enable"},
            {28'h0, wb}, 32'(1 << (off % 4)));
        chk(lat == 2 * w + 4, "R8", {tag, " write latency"}, 32'(lat), 32'(2 * w + 4));
        chk(lk == 2 * w + 3, "R7", {tag, " lock cycles"}, 32'(lk), 32'(2 * w + 3));
        chk(mem_rd(waddr) == exp, "R6", {tag, " backing word after write"}, mem_rd(waddr), exp);
    endtask

    task automatic pass_access(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                               input logic [3:0] be, input int w, input string req);
        logic [31:0] rd, fa, exp; int lat, lk; logic [3:0] wb;
        exp = ref_rd(addr);
        if (we) begin
            for (int i = 0; i < 4; i++) if (be[i]) exp[i*8 +: 8] = wdata[i*8 +: 8];
            ref_mem[addr[31:2]] = exp;
        end
        access(we, addr, wdata, be, w, rd, lat, lk, wb, fa);
        chk(fa == addr, req, "pass address unchanged", fa, addr);
        chk(lat == w, req, "pass adds no cycles", 32'(lat), 32'(w));
        chk(lk == 0, req, "pass unlocked", 32'(lk), 32'h0);
        if (we) chk(wb == be, req, "pass byte enables", {28'h0, wb}, {28'h0, be});
        else    chk(rd == exp, req, "pass read data", rd, exp);
    endtask

    initial begin
        rst_n = 1'b0; up_req = 1'b0; up_we = 1'b0; up_addr = '0; up_wdata = '0; up_be = '0;
        mem[30'h1000_0000] = 32'hA5C3_0F81;  ref_mem[30'h1000_0000] = 32'hA5C3_0F81;
        mem[30'h1000_0001] = 32'h1234_5678;  ref_mem[30'h1000_0001] = 32'h1234_5678;
        mem[30'h1003_FFFF] = 32'h8000_0001;  ref_mem[30'h1003_FFFF] = 32'h8000_0001;
        mem[30'h0800_0004] = 32'hDEAD_BEEF;  ref_mem[30'h0800_0004] = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        #2;
        chk(!up_ready && !dn_req && !dn_lock, "R1", "quiet in reset",
            {29'h0, up_ready, dn_req, dn_lock}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk(!up_ready && !dn_req && !dn_lock, "R1", "quiet after reset",
            {29'h0, up_ready, dn_req, dn_lock}, 32'h0);

        pass_access(1'b0, 32'h2000_0010, 32'h0, 4'hF, 0, "R2");
        pass_access(1'b1, 32'h2000_0010, 32'h0000_00FF, 4'b0001, 2, "R2");
        pass_access(1'b0, 32'h2000_0010, 32'h0, 4'hF, 1, "R2");

        for (int b = 0; b < 8; b++) alias_read(0, b, 1, "R3 byte0 sweep");
        alias_read(5, 1, 0, "R3 lane1");
        alias_read(7, 4, 3, "R8 slow");

        alias_write(6, 2, 32'hFFFF_FFFE, 0, "R6 clear with upper ones");
        alias_write(6, 3, 32'h0000_0001, 1, "R5 set bit");
        alias_write(1, 7, 32'h8000_0000, 3, "R6 bit0 zero");
        alias_read(6, 3, 0, "R5 readback");
        pass_access(1'b0, 32'h4000_0004, 32'h0, 4'hF, 0, "R5");
        pass_access(1'b0, 32'h4000_0000, 32'h0, 4'hF, 2, "R5");

        alias_read(32'hFFFFF, 7, 1, "R9 last alias word");
        pass_access(1'b0, 32'h41FF_FFFC, 32'h0, 4'hF, 1, "R9");
        pass_access(1'b0, 32'h4400_0000, 32'h0, 4'hF, 0, "R9");

        foreach (ref_mem[k])
            chk(mem_rd({k, 2'b00}) == ref_mem[k], "R5", "final memory word",
                mem_rd({k, 2'b00}), ref_mem[k]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule